// File: doc/BRIEF.md
# Banked register file

This block stores the working registers of a small 8-bit processor: sixteen physical 8-bit slots, each addressed by a 4-bit physical index. Instruction fields name registers with 3-bit numbers. A program-controlled bank bit maps the lower four of those numbers onto one of two copies. Numbers 4 to 7 always reach the same fixed slots: two general registers, the stack pointer and the instruction pointer. The upper four slots hold the four segment registers (code, data, extra, stack). Only an explicit physical index reaches them.

The block has two combinational read ports and one write port, which is written on the rising clock edge. Each port carries its own 2-bit mapping mode:
- mode 00 applies the default bank to a 3-bit logical number;
- mode 01 takes the bank from the top bit of the field;
- modes 10 and 11 take the 4-bit index as given.

The bank bit is changed by two dedicated controls, one that sets it to 1 and one that clears it to 0. The current bank is visible as an output.

Top module: `bank_regfile`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, all sixteen slots read 0 and bank_o is 0.
- R2: In modes 10 and 11 the 4-bit sel value is the physical index. Indices 12, 13, 14 and 15 hold the code, data, extra and stack segment registers. These four slots are reachable only in this mode.
- R3: In mode 00, a logical number whose bit 2 is 1 (values 4 to 7) maps to physical index 4 to 7 whatever the bank bit is. Bit 3 of sel is ignored in this mode.
- R4: In mode 00, a logical number whose bit 2 is 0 maps to physical index {bank, 0, sel[1:0]}. Bank 0 gives slots 0 to 3 and bank 1 gives slots 8 to 11.
- R5: In mode 01, the physical index is {sel[2], 0, sel[1:0]}: sel[2] chooses the bank in place of the default bank, and sel[3] is ignored.
- R6: bank_set high makes bank_o 1 after the next rising edge, and bank_clr high alone makes it 0. When both are high, set wins. When neither is high, the bit holds.
- R7: The slot selected by the write port takes wr_data on a rising edge when wr_en is high. When wr_en is low, no slot changes.
- R8: A read of the slot being written returns the old value until the edge. The new value appears on the read port from the following cycle.
- R9: A bank change takes effect on the mappings from the cycle after the edge. A write issued in the same cycle as a bank change uses the old bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_set | input | 1 | Set the default bank to 1 |
| bank_clr | input | 1 | Clear the default bank to 0 |
| bank_o | output | 1 | Current default bank |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 2 | Mapping mode of the write port |
| wr_sel | input | 4 | Logical number (bits 2:0) or physical index of the write port |
| wr_data | input | 8 | Write data |
| rd_a_mode | input | 2 | Mapping mode of read port A |
| rd_a_sel | input | 4 | Register selector of read port A |
| rd_a_data | output | 8 | Read data of port A |
| rd_b_mode | input | 2 | Mapping mode of read port B |
| rd_b_sel | input | 4 | Register selector of read port B |
| rd_b_data | output | 8 | Read data of port B |

## Verification
The assertions assume the following:
- every control and selector input is known (no X) once reset is released;
- bank_set and bank_clr may be high together, and set then has priority;
- the checks that compare two read ports hold only while the write port does not change the state between the sampled edges, because they compare outputs in the same cycle.

The stimulus uses only the four defined mode codes and full 4-bit selectors, including the ignored bit 3. It changes all inputs on the falling edge so that every rising edge sees settled values. It raises the two bank controls rarely, and sometimes together, so that both banks are used for long stretches.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

   typedef enum logic [1:0] {
      MAP_LOGICAL  = 2'b00,
      MAP_EXPLICIT = 2'b01,
      MAP_PHYS     = 2'b10,
      MAP_PHYS_ALT = 2'b11
   } map_mode_e;

endpackage

// File: rtl/reg_index_map.sv
module reg_index_map
   import regfile_pkg::*;
#(
   parameter int LOG_W = 3
) (
   input  logic [1:0]     mode_i,
   input  logic [LOG_W:0] sel_i,
   input  logic           bank_i,
   output logic [LOG_W:0] idx_o
);

   generate
      if (LOG_W < 2) begin : g_bad_width
         $error("reg_index_map: LOG_W must be at least 2");
      end
   endgenerate

   always_comb begin
      case (map_mode_e'(mode_i))
         MAP_LOGICAL:  idx_o = {(sel_i[LOG_W-1] ? 1'b0 : bank_i), sel_i[LOG_W-1:0]};
         MAP_EXPLICIT: idx_o = {sel_i[LOG_W-1], 1'b0, sel_i[LOG_W-2:0]};
         default:      idx_o = sel_i;
      endcase
   end

endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic bank_o
);

   logic bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bank_q <= 1'b0;
      else if (set_i) bank_q <= 1'b1;
      else if (clr_i) bank_q <= 1'b0;
   end

   assign bank_o = bank_q;

   AST_BANK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> bank_q); // R6
   AST_BANK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !bank_q); // R6
   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(bank_q)); // R6

endmodule

// File: rtl/reg_store.sv
module reg_store #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_a_i,
   output logic [DATA_W-1:0] rdata_a_o,
   input  logic [IDX_W-1:0]  ridx_b_i,
   output logic [DATA_W-1:0] rdata_b_o
);

   localparam int NREG = 1 << IDX_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("reg_store: DATA_W must be positive");
      end
      if (IDX_W > 8) begin : g_bad_idx
         $error("reg_store: IDX_W too large for a flop array");
      end
   endgenerate

   logic [DATA_W-1:0] slot_q [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[g] <= '0;
            else if (we_i && (widx_i == IDX_W'(g)))
               slot_q[g] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_a_o = slot_q[ridx_a_i];
   assign rdata_b_o = slot_q[ridx_b_i];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (slot_q[$past(widx_i)] == $past(wdata_i))); // R7

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
   import regfile_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LOG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_set,
   input  logic              bank_clr,
   output logic              bank_o,
   input  logic              wr_en,
   input  logic [1:0]        wr_mode,
   input  logic [LOG_W:0]    wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_a_mode,
   input  logic [LOG_W:0]    rd_a_sel,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [1:0]        rd_b_mode,
   input  logic [LOG_W:0]    rd_b_sel,
   output logic [DATA_W-1:0] rd_b_data
);

   localparam int IDX_W = LOG_W + 1;
   localparam int NPORT = 3;

   logic                        bank;
   logic [NPORT-1:0][1:0]       mode_v;
   logic [NPORT-1:0][IDX_W-1:0] sel_v;
   logic [NPORT-1:0][IDX_W-1:0] idx_v;

   assign mode_v = {rd_b_mode, rd_a_mode, wr_mode};
   assign sel_v  = {rd_b_sel, rd_a_sel, wr_sel};

   bank_ctrl u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (bank_set),
      .clr_i  (bank_clr),
      .bank_o (bank)
   );

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_map
         reg_index_map #(.LOG_W(LOG_W)) u_map (
            .mode_i (mode_v[p]),
            .sel_i  (sel_v[p]),
            .bank_i (bank),
            .idx_o  (idx_v[p])
         );
      end
   endgenerate

   reg_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (wr_en),
      .widx_i    (idx_v[0]),
      .wdata_i   (wr_data),
      .ridx_a_i  (idx_v[1]),
      .rdata_a_o (rd_a_data),
      .ridx_b_i  (idx_v[2]),
      .rdata_b_o (rd_b_data)
   );

   assign bank_o = bank;

   AST_FIXED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_mode == MAP_LOGICAL && rd_a_sel[LOG_W-1] && rd_b_mode[1]
       && rd_b_sel == {1'b0, rd_a_sel[LOG_W-1:0]})
      |-> (rd_a_data == rd_b_data)); // R3
   AST_BANKED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_mode == MAP_LOGICAL && !rd_a_sel[LOG_W-1] && rd_b_mode[1]
       && rd_b_sel == {bank_o, rd_a_sel[LOG_W-1:0]})
      |-> (rd_a_data == rd_b_data)); // R4

endmodule

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
module sim_bank_regfile;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bank_set = 1'b0, bank_clr = 1'b0, bank_o;
   logic       wr_en = 1'b0;
   logic [1:0] wr_mode = 2'b10, rd_a_mode = 2'b10, rd_b_mode = 2'b10;
   logic [3:0] wr_sel = '0, rd_a_sel = '0, rd_b_sel = '0;
   logic [7:0] wr_data = '0, rd_a_data, rd_b_data;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;
   logic [7:0] exp_q [16];
   logic       exp_bank;

   always #2 clk = ~clk;

   bank_regfile u0 (.*);

   function automatic logic [3:0] map_idx(logic [1:0] m, logic [3:0] s, logic b);
      if (m == 2'b00)      return s[2] ? {1'b0, s[2:0]} : {b, 1'b0, s[1:0]};
      else if (m == 2'b01) return {s[2], 1'b0, s[1:0]};
      else                 return s;
   endfunction

   function automatic string tag_of(logic [1:0] m, logic [3:0] s);
      if (m[1])      return "R2";
      if (m == 2'b01) return "R5";
      return s[2] ? "R3" : "R4";
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic check_reads();
      #1;
      chk(tag_of(rd_a_mode, rd_a_sel), rd_a_data, exp_q[map_idx(rd_a_mode, rd_a_sel, exp_bank)]);
      chk(tag_of(rd_b_mode, rd_b_sel), rd_b_data, exp_q[map_idx(rd_b_mode, rd_b_sel, exp_bank)]);
      chk("R6", {7'd0, bank_o}, {7'd0, exp_bank});
   endtask

   task automatic tick();
      @(posedge clk);
      if (wr_en) exp_q[map_idx(wr_mode, wr_sel, exp_bank)] = wr_data;
      if (bank_set)      exp_bank = 1'b1;
      else if (bank_clr) exp_bank = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] m, input logic [3:0] s, input logic [7:0] d);
      wr_en = 1'b1; wr_mode = m; wr_sel = s; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd_a(input logic [1:0] m, input logic [3:0] s);
      rd_a_mode = m; rd_a_sel = s;
      #1;
   endtask

   initial begin
      #800000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 16; i++) exp_q[i] = '0;
      exp_bank = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state, while reset is still held
      for (int i = 0; i < 16; i++) begin
         rd_a(2'b10, 4'(i));
         chk("R1", rd_a_data, 8'h00);
      end
      chk("R1", {7'd0, bank_o}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         rd_a(2'b11, 4'(i));
         chk("R1", rd_a_data, 8'h00);
      end

      // R2: segment slots via physical index
      for (int i = 12; i < 16; i++) wr(2'b10, 4'(i), 8'hC0 + 8'(i));
      for (int i = 12; i < 16; i++) begin
         rd_a(2'b10, 4'(i));
         chk("R2", rd_a_data, 8'hC0 + 8'(i));
      end
      // R3: logical 4..7 never reach the segment slots, bit 3 ignored
      for (int i = 12; i < 16; i++) begin
         rd_a(2'b00, 4'(i));
         chk("R3", rd_a_data, 8'h00);
      end

      // R7: write disabled leaves slot untouched
      wr_en = 1'b0; wr_mode = 2'b10; wr_sel = 4'd3; wr_data = 8'hAA;
      tick();
      rd_a(2'b10, 4'd3);
      chk("R7", rd_a_data, 8'h00);

      // R8: same-cycle read returns old value
      wr_en = 1'b1; wr_mode = 2'b10; wr_sel = 4'd5; wr_data = 8'h5A;
      rd_a(2'b10, 4'd5);
      chk("R8", rd_a_data, 8'h00);
      tick();
      wr_en = 1'b0;
      rd_a(2'b10, 4'd5);
      chk("R8", rd_a_data, 8'h5A);

      // R6: bank controls
      bank_set = 1'b1; tick(); bank_set = 1'b0; #1;
      chk("R6", {7'd0, bank_o}, 8'h01);
      bank_set = 1'b1; bank_clr = 1'b1; tick(); bank_set = 1'b0; bank_clr = 1'b0; #1;
      chk("R6", {7'd0, bank_o}, 8'h01);
      tick(); #1;
      chk("R6", {7'd0, bank_o}, 8'h01);
      bank_clr = 1'b1; tick(); bank_clr = 1'b0; #1;
      chk("R6", {7'd0, bank_o}, 8'h00);

      // R9: write in the same cycle as a bank change uses the old bank
      bank_set = 1'b1;
      wr(2'b00, 4'd1, 8'h11);
      bank_set = 1'b0;
      rd_a(2'b10, 4'd1);  chk("R9", rd_a_data, 8'h11);
      rd_a(2'b10, 4'd9);  chk("R9", rd_a_data, 8'h00);
      rd_a(2'b00, 4'd1);  chk("R9", rd_a_data, 8'h00);
      wr(2'b00, 4'd1, 8'h99);
      rd_a(2'b10, 4'd9);  chk("R4", rd_a_data, 8'h99);

      // R5: explicit bank from field top bit, regardless of default bank
      bank_clr = 1'b1; tick(); bank_clr = 1'b0;
      wr(2'b01, 4'b1110, 8'h3C);
      rd_a(2'b10, 4'd10); chk("R5", rd_a_data, 8'h3C);
      rd_a(2'b01, 4'b0010); chk("R5", rd_a_data, 8'h00);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         wr_en     = ($urandom_range(0, 2) != 0);
         wr_mode   = 2'($urandom);
         wr_sel    = 4'($urandom);
         wr_data   = 8'($urandom);
         rd_a_mode = 2'($urandom);
         rd_a_sel  = 4'($urandom);
         rd_b_mode = 2'($urandom);
         rd_b_sel  = 4'($urandom);
         bank_set  = ($urandom_range(0, 15) == 0);
         bank_clr  = ($urandom_range(0, 15) == 0);
         check_reads();
         tick();
      end
      wr_en = 1'b0; bank_set = 1'b0; bank_clr = 1'b0;
      for (int i = 0; i < 16; i++) begin
         rd_a(2'b10, 4'(i));
         chk("R7", rd_a_data, exp_q[i]);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule